// File: doc/BRIEF.md
# Slave-Select Watchdog Supervisor

This block watches the slave-select line of a serial peripheral port and uses it as a keep-alive signal from the host. To service the watchdog, the host pulls slave select low and releases it again without moving any data. If that does not happen within a programmable number of prescaler ticks, the block drives a CPU reset pulse. The pulse lasts a programmable number of ticks. At the same moment the block sets a sticky watchdog flag, which software later finds in its status word.

The enable bit and the flag are separate signals here. The surrounding register block maps them into its control and status registers. The status-read strobe tells the block that status has been read, and that read clears the flag. The tick input is a single-cycle enable from a shared prescaler. All inputs are assumed to be synchronous to `clk`.

Top module: `ssw_watchdog`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), cpu_rst_o and wd_flag_o are both 0.
- R2: While enabled and unserviced, the watchdog expires on the tick that brings the number of ticks counted since the last restart up to win_i. At that clock edge, cpu_rst_o and wd_flag_o both go to 1.
- R3: A clean service restarts the tick count from zero. A clean service is slave select going low (ss_n_i = 0) and then high again, with xfer_i = 0 in every cycle of the select, including the cycle of the rising edge. The restart happens at the rising (deasserting) edge.
- R4: A select during which xfer_i is 1 in any cycle is a data transfer and does not service the watchdog.
- R5: cpu_rst_o stays 1 for pulse_len_i ticks. It then returns to 0, and counting restarts from zero.
- R6: A service that arrives while the reset pulse is active is ignored. It neither shortens the pulse nor changes its length.
- R7: wd_flag_o stays 1 until a cycle with stat_rd_i = 1 clears it. If a read and an expiry fall in the same cycle, the flag ends that cycle as 1.
- R8: While wd_en_i is 0, cpu_rst_o is 0 from the next edge, including when a pulse was in progress. No expiry happens, and counting starts from zero when the block is enabled again. The first cycle after enabling is a load cycle.
- R9: When a clean service and a tick fall in the same cycle, the service wins and the count becomes zero.
- R10: A win_i or pulse_len_i value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle prescaler tick |
| ss_n_i | input | 1 | Slave select, active low |
| xfer_i | input | 1 | High in cycles where serial data moves |
| wd_en_i | input | 1 | Watchdog enable bit |
| stat_rd_i | input | 1 | Status-read strobe, clears the flag |
| win_i | input | CNT_W | Service window in ticks |
| pulse_len_i | input | PLS_W | Reset pulse length in ticks |
| cpu_rst_o | output | 1 | CPU reset pulse, active high |
| wd_flag_o | output | 1 | Sticky watchdog-expired flag |

## Verification
The bench runs selects that carry data, both at the falling edge and midway through the select. A design that treated any toggle as service would miss these expiries. It sends a service during the reset pulse, which would shorten the pulse if it were honoured. It puts a service on the same cycle as a tick, which a wrong priority would turn into a count of one and an early expiry. It also places a status read on the expiry cycle, where the wrong ordering would lose the flag. Other directed cases cover disabling mid-pulse, where a design that let the pulse finish would keep the CPU in reset. Zero-valued window and pulse settings are checked too; a wrapping compare would turn them into a huge timeout.

// File: rtl/wdog_pkg.sv
// Shared types for the slave-select watchdog.
package wdog_pkg;
    // States of the window timer.
    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,  // disabled or loading
        WD_COUNT = 2'd1,  // counting ticks toward the window
        WD_PULSE = 2'd2   // driving the CPU reset pulse
    } wd_state_t;
endpackage

// File: rtl/ssw_select_monitor.sv
// Watches slave select and reports a clean service. A clean service is a
// select that is released with no data moved while it was held. The service
// strobe is combinational and high in the cycle where ss_n_i rises.
// Assumes ss_n_i and xfer_i are already synchronous to clk.
module ssw_select_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_n_i,
    input  logic xfer_i,
    output logic svc_o
);
    logic ss_q;
    logic dirty_q;

    // Track the previous select level and whether this select carried data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_q    <= 1'b1;
            dirty_q <= 1'b0;
        end else begin
            ss_q <= ss_n_i;
            if (!ss_n_i) begin
                dirty_q <= ss_q ? xfer_i : (dirty_q | xfer_i);
            end else begin
                dirty_q <= 1'b0;
            end
        end
    end

    // Service on a rising select edge when no data moved during the select.
    always_comb begin
        svc_o = !ss_q && ss_n_i && !dirty_q && !xfer_i;
    end

    // R4: a transfer cycle inside a select never leads to service next cycle
    a_r4_xfer_blocks_service: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n_i && xfer_i) |=> !svc_o);

    // R3: service only occurs on a rising edge of slave select
    a_r3_service_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        svc_o |-> (ss_n_i && !ss_q));
endmodule

// File: rtl/ssw_window_timer.sv
// Counts prescaler ticks between services. When the count reaches the window,
// it raises a one-cycle expiry strobe and then holds the CPU reset high for a
// programmed number of ticks. Assumes tick_i is a single-cycle enable. A zero
// window or pulse length is taken as one.
module ssw_window_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PLS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             svc_i,
    input  logic [CNT_W-1:0] win_i,
    input  logic [PLS_W-1:0] plen_i,
    output logic             expire_o,
    output logic             cpu_rst_o
);
    localparam int CW1 = CNT_W + 1;
    localparam int PW1 = PLS_W + 1;

    wd_state_t        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PLS_W-1:0] pcnt_q;
    logic             win_hit;
    logic             pls_hit;

    // Compare the next count against the limit, so that 0 and 1 behave alike.
    always_comb begin
        win_hit = ({1'b0, cnt_q} + CW1'(1)) >= {1'b0, win_i};
        pls_hit = ({1'b0, pcnt_q} + PW1'(1)) >= {1'b0, plen_i};
    end

    // Expiry: a tick in the counting state, with no service, reaching the window.
    always_comb begin
        expire_o = (state_q == WD_COUNT) && en_i && !svc_i && tick_i && win_hit;
    end

    // Reset output comes straight from the pulse state.
    always_comb begin
        cpu_rst_o = (state_q == WD_PULSE);
    end

    // State and counters: the enable overrides everything, and service beats a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
            cnt_q   <= '0;
            pcnt_q  <= '0;
        end else if (!en_i) begin
            state_q <= WD_IDLE;
            cnt_q   <= '0;
            pcnt_q  <= '0;
        end else begin
            unique case (state_q)
                WD_IDLE: begin
                    state_q <= WD_COUNT;
                    cnt_q   <= '0;
                end
                WD_COUNT: begin
                    if (svc_i) begin
                        cnt_q <= '0;
                    end else if (tick_i) begin
                        if (win_hit) begin
                            state_q <= WD_PULSE;
                            pcnt_q  <= '0;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                WD_PULSE: begin
                    if (tick_i) begin
                        if (pls_hit) begin
                            state_q <= WD_COUNT;
                            cnt_q   <= '0;
                        end else begin
                            pcnt_q <= pcnt_q + PLS_W'(1);
                        end
                    end
                end
                default: begin
                    state_q <= WD_IDLE;
                end
            endcase
        end
    end

    // R2: an expiry starts the reset pulse at the next edge
    a_r2_expire_starts_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> cpu_rst_o);

    // R8: with the enable low, the reset output is low from the next edge
    a_r8_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !cpu_rst_o);

    // R6: a pulse continues while enabled and no terminal tick arrives
    a_r6_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rst_o && en_i && !(tick_i && pls_hit)) |=> cpu_rst_o);

    // R5: when the pulse ends with the enable high, counting restarts at zero
    a_r5_restart_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cpu_rst_o) && $past(en_i)) |-> (state_q == WD_COUNT && cnt_q == '0));

    // R9: a service in the counting state clears the count
    a_r9_service_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_i && en_i && state_q == WD_COUNT) |=> (cnt_q == '0));
endmodule

// File: rtl/ssw_status_flag.sv
// Sticky watchdog flag. An expiry sets it and a status read clears it.
// When both happen in one cycle, the set wins so no expiry is lost.
module ssw_status_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    output logic flag_o
);
    // Hold the flag: set has priority over a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (rd_i) begin
            flag_o <= 1'b0;
        end
    end

    // R7: an expiry always leaves the flag set, even with a read in that cycle
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R7: a read without an expiry clears the flag
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/ssw_watchdog.sv
// Slave-select watchdog supervisor, top level. It joins the select monitor,
// the window timer and the status flag. Assumes every input is synchronous
// to clk and that tick_i comes from a shared prescaler.
module ssw_watchdog #(
    parameter int CNT_W = 16,
    parameter int PLS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ss_n_i,
    input  logic             xfer_i,
    input  logic             wd_en_i,
    input  logic             stat_rd_i,
    input  logic [CNT_W-1:0] win_i,
    input  logic [PLS_W-1:0] pulse_len_i,
    output logic             cpu_rst_o,
    output logic             wd_flag_o
);
    logic svc;
    logic expire;

    ssw_select_monitor u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .ss_n_i (ss_n_i),
        .xfer_i (xfer_i),
        .svc_o  (svc)
    );

    ssw_window_timer #(
        .CNT_W (CNT_W),
        .PLS_W (PLS_W)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (wd_en_i),
        .tick_i    (tick_i),
        .svc_i     (svc),
        .win_i     (win_i),
        .plen_i    (pulse_len_i),
        .expire_o  (expire),
        .cpu_rst_o (cpu_rst_o)
    );

    ssw_status_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (expire),
        .rd_i   (stat_rd_i),
        .flag_o (wd_flag_o)
    );

    // R1: both outputs are low in the cycle after a reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!cpu_rst_o && !wd_flag_o));
endmodule

// File: tb/sim_ssw_watchdog.sv
// Bench for ssw_watchdog. A vector table is walked first, then directed tests.
module sim_ssw_watchdog;
    localparam int CNT_W = 16;
    localparam int PLS_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             tick, ss_n, xfer, en, rd;
    logic [CNT_W-1:0] win;
    logic [PLS_W-1:0] plen;
    logic             cpu_rst, flag;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    ssw_watchdog #(.CNT_W(CNT_W), .PLS_W(PLS_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .ss_n_i(ss_n), .xfer_i(xfer),
        .wd_en_i(en), .stat_rd_i(rd), .win_i(win), .pulse_len_i(plen),
        .cpu_rst_o(cpu_rst), .wd_flag_o(flag)
    );

    // Vector layout: req[10:7] tick[6] ss_n[5] xfer[4] en[3] rd[2] exp_rst[1] exp_flag[0]
    // Table assumes win = 3, pulse length = 2, starting from reset.
    localparam int NV = 51;
    localparam logic [10:0] VEC [NV] = '{
        {4'd8, 5'b01010, 2'b00},  // 0  R8 enable: load cycle
        {4'd2, 5'b11010, 2'b00},  // 1  R2 count 1
        {4'd2, 5'b11010, 2'b00},  // 2  R2 count 2
        {4'd2, 5'b11010, 2'b11},  // 3  R2 expiry
        {4'd5, 5'b01010, 2'b11},  // 4  R5 pulse held, no tick
        {4'd5, 5'b11010, 2'b11},  // 5  R5 pulse tick 1
        {4'd5, 5'b11010, 2'b01},  // 6  R5 pulse ends
        {4'd7, 5'b01011, 2'b00},  // 7  R7 read clears
        {4'd3, 5'b11010, 2'b00},  // 8  count 1
        {4'd3, 5'b11010, 2'b00},  // 9  count 2
        {4'd3, 5'b00010, 2'b00},  // 10 R3 select, clean
        {4'd3, 5'b01010, 2'b00},  // 11 R3 release: service
        {4'd3, 5'b11010, 2'b00},  // 12 R3 count 1
        {4'd3, 5'b11010, 2'b00},  // 13 R3 count 2, no expiry
        {4'd4, 5'b00110, 2'b00},  // 14 R4 select with data
        {4'd4, 5'b01010, 2'b00},  // 15 R4 release, no service
        {4'd4, 5'b11010, 2'b11},  // 16 R4 expiry proves no service
        {4'd6, 5'b00010, 2'b11},  // 17 R6 select in pulse
        {4'd6, 5'b01010, 2'b11},  // 18 R6 release ignored
        {4'd6, 5'b11010, 2'b11},  // 19 R6 pulse tick 1
        {4'd6, 5'b11010, 2'b01},  // 20 R6 full length pulse
        {4'd7, 5'b11010, 2'b01},  // 21 count 1
        {4'd7, 5'b11010, 2'b01},  // 22 count 2
        {4'd7, 5'b11011, 2'b11},  // 23 R7 read on expiry keeps flag
        {4'd8, 5'b01000, 2'b01},  // 24 R8 disable mid-pulse
        {4'd8, 5'b11000, 2'b01},  // 25 R8 tick ignored
        {4'd8, 5'b11000, 2'b01},  // 26 R8 tick ignored
        {4'd8, 5'b11000, 2'b01},  // 27 R8 tick ignored
        {4'd7, 5'b01001, 2'b00},  // 28 R7 read clears
        {4'd8, 5'b01010, 2'b00},  // 29 R8 re-enable load
        {4'd8, 5'b11010, 2'b00},  // 30 R8 count 1
        {4'd8, 5'b11010, 2'b00},  // 31 R8 count 2
        {4'd8, 5'b11010, 2'b11},  // 32 R8 expiry after full window
        {4'd7, 5'b01011, 2'b10},  // 33 R7 read during pulse
        {4'd5, 5'b11010, 2'b10},  // 34 R5 pulse tick 1
        {4'd5, 5'b11010, 2'b00},  // 35 R5 pulse ends
        {4'd4, 5'b11010, 2'b00},  // 36 count 1
        {4'd4, 5'b00010, 2'b00},  // 37 R4 select clean start
        {4'd4, 5'b00110, 2'b00},  // 38 R4 data mid-select
        {4'd4, 5'b01010, 2'b00},  // 39 R4 release, no service
        {4'd4, 5'b11010, 2'b00},  // 40 R4 count 2
        {4'd4, 5'b11010, 2'b11},  // 41 R4 expiry
        {4'd5, 5'b11010, 2'b11},  // 42 pulse tick 1
        {4'd5, 5'b11010, 2'b01},  // 43 pulse ends
        {4'd9, 5'b11011, 2'b00},  // 44 count 1, read
        {4'd9, 5'b11010, 2'b00},  // 45 count 2
        {4'd9, 5'b00010, 2'b00},  // 46 R9 select
        {4'd9, 5'b11010, 2'b00},  // 47 R9 release with tick: count 0
        {4'd9, 5'b11010, 2'b00},  // 48 R9 count 1
        {4'd9, 5'b11010, 2'b00},  // 49 R9 count 2
        {4'd9, 5'b11010, 2'b11}   // 50 R9 expiry on third tick
    };

    // Drive one cycle of inputs after a falling edge; return at the next falling edge.
    task automatic cyc(input logic t, input logic s, input logic x,
                       input logic e, input logic r);
        tick = t; ss_n = s; xfer = x; en = e; rd = r;
        @(negedge clk);
    endtask

    // Compare both outputs against expected values and log any mismatch.
    task automatic check(input string req, input logic er, input logic ef);
        n_chk++;
        if (cpu_rst !== er || flag !== ef) begin
            n_fail++;
            $display("FAIL %s: rst=%b flag=%b expected rst=%b flag=%b",
                     req, cpu_rst, flag, er, ef);
        end
    endtask

    // Apply a synchronous reset of two cycles.
    task automatic do_reset();
        rst_n = 1'b0;
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick = 0; ss_n = 1; xfer = 0; en = 0; rd = 0;
        win = 16'd3; plen = 8'd2; rst_n = 1'b0;
        @(negedge clk);
        do_reset();
        check("R1", 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [10:0] v;
            v = VEC[i];
            cyc(v[6], v[5], v[4], v[3], v[2]);
            check($sformatf("R%0d vec%0d", v[10:7], i), v[1], v[0]);
        end

        // R1: reset during a pulse clears both outputs
        win = 16'd1; plen = 8'd4;
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R1 pre-reset pulse", 1'b1, 1'b1);
        rst_n = 1'b0;
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        rst_n = 1'b1;
        check("R1 reset mid-pulse", 1'b0, 1'b0);

        // R10: zero window and zero pulse length behave as one
        do_reset();
        win = 16'd0; plen = 8'd0;
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R10 load", 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R10 zero window expires on first tick", 1'b1, 1'b1);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R10 zero pulse ends on first tick", 1'b0, 1'b1);

        // R5: longer pulse with gaps between ticks
        do_reset();
        win = 16'd2; plen = 8'd3;
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R5 expiry win=2", 1'b1, 1'b1);
        for (int k = 0; k < 2; k++) begin
            cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
            cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
            check("R5 pulse still high", 1'b1, 1'b1);
        end
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R5 pulse ends after 3 ticks", 1'b0, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule